// File: doc/BRIEF.md
# Connection Memory Block Programmer

This controller fills the whole connection memory of a time slot switch in a single pass. Software loads a 3-bit pattern, sets an arm bit, and then raises a start bit in the control register. The block waits for the next frame pulse and then writes one memory word per clock, from the lowest address to the highest. Each word receives the pattern in its top three bits, and all of its lower bits are cleared. A typical use is to put every output channel into a known drive state right after reset.

The block also sits between the microprocessor and the memory write port. When the controller is idle, microprocessor writes pass straight through. From the accepted start until the end of the pass, a busy flag holds those writes off. The microprocessor keeps its request raised, and the write is carried out once busy drops. At the end of the pass the hardware clears the start bit and raises a one-cycle done pulse. The pass begins at a frame boundary and lasts at most one frame, so the whole operation fits within two frames of the start.

Top module: `cm_block_prog`

## Requirements
- R1: During and right after reset, the control register reads 0, and busy, done and the memory write strobe are all 0.
- R2: A control register write while idle is stored and read back unchanged in the same layout: arm at bit 11, pattern at bits 9:7, start at bit 6.
- R3: A register write that takes start from 0 to 1 with arm = 1 in the written value raises busy on the next clock. The sweep's first write happens in the cycle after the first frame pulse that is sampled while busy.
- R4: The sweep drives the memory write strobe for 2^AW consecutive clocks. The addresses run 0, 1, ..., 2^AW-1, and the data is the pattern in bits DW-1:DW-3 with zeros below.
- R5: In the clock after the last sweep write, start reads 0 and busy is 0. Done is high for exactly that one clock.
- R6: A start rising edge written with arm = 0 is stored but starts nothing: busy stays 0 and no memory write occurs.
- R7: While idle, a microprocessor request drives the memory write strobe, address and data in the same cycle. While busy, it drives none of them, and a request that is held is performed once busy falls.
- R8: Control register writes presented while busy are discarded: the read-back value does not change.
- R9: Writing start = 1 with arm = 1 while start already reads 1 is not a rising edge and starts nothing.
- R10: When 2^AW does not exceed the frame length, done follows the accepted start within two frame lengths of clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cr_we | input | 1 | Control register write strobe |
| cr_wdata | input | 16 | Control register write data |
| cr_rdata | output | 16 | Control register contents |
| frame_pulse | input | 1 | One-clock frame boundary marker |
| up_req | input | 1 | Microprocessor memory write request, held until accepted |
| up_addr | input | AW | Microprocessor write address |
| up_wdata | input | DW | Microprocessor write data |
| up_busy | output | 1 | High while a programming pass is pending or running |
| cm_we | output | 1 | Connection memory write strobe |
| cm_addr | output | AW | Connection memory write address |
| cm_wdata | output | DW | Connection memory write data |
| done | output | 1 | One-cycle pulse when the pass completes |

## Verification
Suppose the address counter or the phase state goes wrong. The effect shows at the memory port on the next clock, as a skipped or repeated address, as a write during the wait phase, or as a microprocessor write getting through while busy is high. A wrong start-edge decision shows within one clock as busy rising, or failing to rise. A miscounted end shows after the pass, either as done arriving in the wrong cycle or as the start bit still reading 1. A word corrupted by a lost or extra write shows up when the bench compares its shadow copy of the memory against the expected contents.

// File: rtl/cm_block_prog.sv
module cm_block_prog #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int FRAME_LEN = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cr_we,
  input  logic [15:0]   cr_wdata,
  output logic [15:0]   cr_rdata,
  input  logic          frame_pulse,
  input  logic          up_req,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_wdata,
  output logic          up_busy,
  output logic          cm_we,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_wdata,
  output logic          done
);
  localparam int ARM_BIT   = 11;
  localparam int START_BIT = 6;
  localparam int PAT_LO    = 7;
  localparam int PAT_W     = 3;
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  if ((2 ** AW) > FRAME_LEN) begin : g_len_chk
    $error("sweep longer than one frame");
  end

  typedef enum logic [1:0] {IDLE, WAIT, SWEEP} phase_t;

  phase_t          phase;
  logic [AW-1:0]   cnt;
  logic [15:0]     cr;
  logic            start_edge;

  assign start_edge = cr_we && !cr[START_BIT] && cr_wdata[START_BIT] && cr_wdata[ARM_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= IDLE;
      cnt   <= '0;
      cr    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        IDLE: if (cr_we) begin
          cr <= cr_wdata;
          if (start_edge) phase <= WAIT;
        end
        WAIT: if (frame_pulse) begin
          phase <= SWEEP;
          cnt   <= '0;
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            phase         <= IDLE;
            cr[START_BIT] <= 1'b0;
            done          <= 1'b1;
          end
        end
      endcase
    end
  end

  assign cr_rdata = cr;
  assign up_busy  = (phase != IDLE);
  assign cm_we    = (phase == SWEEP) || (up_req && !up_busy);
  assign cm_addr  = (phase == SWEEP) ? cnt : up_addr;
  assign cm_wdata = (phase == SWEEP) ? {cr[PAT_LO +: PAT_W], {(DW-PAT_W){1'b0}}} : up_wdata;
endmodule

module cm_block_prog_chk #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int FRAME_LEN = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   cr_rdata,
  input logic          up_req,
  input logic [AW-1:0] up_addr,
  input logic [DW-1:0] up_wdata,
  input logic          up_busy,
  input logic          cm_we,
  input logic [AW-1:0] cm_addr,
  input logic [DW-1:0] cm_wdata,
  input logic          done
);
  logic [31:0] wcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= '0;
    else if (up_busy) wcnt <= wcnt + 1;
    else wcnt <= '0;
  end

  assert_first_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_we && up_busy && !$past(cm_we && up_busy)) |-> (cm_addr == '0));
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_we && up_busy && $past(cm_we && up_busy)) |-> (cm_addr == AW'($past(cm_addr) + 1)));
  assert_low_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_we && up_busy) |-> (cm_wdata[DW-4:0] == '0));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_clears_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cr_rdata[6] && !up_busy && $past(cm_we) && $past(cm_addr) == {AW{1'b1}}));
  assert_cpu_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && !up_busy) |-> (cm_we && cm_addr == up_addr && cm_wdata == up_wdata));
  assert_cr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_busy && $past(up_busy)) |-> $stable(cr_rdata));
  assert_two_frames_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= 32'(2 * FRAME_LEN));
endmodule

bind cm_block_prog cm_block_prog_chk #(.AW(AW), .DW(DW), .FRAME_LEN(FRAME_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cr_rdata(cr_rdata), .up_req(up_req), .up_addr(up_addr),
  .up_wdata(up_wdata), .up_busy(up_busy), .cm_we(cm_we), .cm_addr(cm_addr),
  .cm_wdata(cm_wdata), .done(done));

// File: tb/cm_block_prog_bench.sv
module cm_block_prog_bench;
  localparam int AW = 8, DW = 16, FRAME = 300, N = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cr_we = 0, frame_pulse = 0, up_req = 0;
  logic [15:0] cr_wdata = 0;
  logic [AW-1:0] up_addr = 0;
  logic [DW-1:0] up_wdata = 0;
  logic [15:0] cr_rdata;
  logic up_busy, cm_we, done;
  logic [AW-1:0] cm_addr;
  logic [DW-1:0] cm_wdata;

  cm_block_prog #(.AW(AW), .DW(DW), .FRAME_LEN(FRAME)) u_cm_block_prog (
    .clk(clk), .rst_n(rst_n), .cr_we(cr_we), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
    .frame_pulse(frame_pulse), .up_req(up_req), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_busy(up_busy), .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata), .done(done));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, fcnt = 0, writes = 0;
  bit finished = 0;
  logic [DW-1:0] mem [N];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model: phase 0 idle, 1 waiting for frame, 2 sweeping
  int mph = 0, mcnt = 0;
  logic [15:0] mcr = 0;
  bit mdone = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      mdone = 0;
      if (mph == 0) begin
        if (cr_we) begin
          if (!mcr[6] && cr_wdata[6] && cr_wdata[11]) mph = 1;
          mcr = cr_wdata;
        end
      end else if (mph == 1) begin
        if (frame_pulse) begin mph = 2; mcnt = 0; end
      end else begin
        if (mcnt == N - 1) begin mph = 0; mcr[6] = 0; mdone = 1; end
        else mcnt++;
      end
    end
  end

  always @(negedge clk) begin
    fcnt = (fcnt == FRAME - 1) ? 0 : fcnt + 1;
    frame_pulse <= (fcnt == 0);
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      bit mw;
      logic [AW-1:0] ma;
      logic [DW-1:0] md;
      mw = (mph == 2) || (up_req && mph == 0);
      ma = (mph == 2) ? AW'(mcnt) : up_addr;
      md = (mph == 2) ? {mcr[9:7], 13'b0} : up_wdata;
      check(up_busy == (mph != 0), "R3", up_busy, mph != 0);
      check(cm_we == mw, (mph == 2) ? "R4" : "R7", cm_we, mw);
      if (mw) begin
        check(cm_addr == ma, (mph == 2) ? "R4" : "R7", cm_addr, ma);
        check(cm_wdata == md, (mph == 2) ? "R4" : "R7", cm_wdata, md);
      end
      check(done == mdone, "R5", done, mdone);
      check(cr_rdata == mcr, "R2", cr_rdata, mcr);
      if (cm_we) begin mem[cm_addr] = cm_wdata; writes++; end
    end
  end

  task automatic cr_write(input logic [15:0] v);
    @(negedge clk); cr_we = 1; cr_wdata = v;
    @(negedge clk); cr_we = 0;
  endtask

  task automatic cpu_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); up_req = 1; up_addr = a; up_wdata = d; #1;
    while (up_busy) begin @(negedge clk); #1; end
    @(negedge clk); up_req = 0;
  endtask

  function automatic logic [15:0] crv(input bit arm, input logic [2:0] pat, input bit st);
    return (16'(arm) << 11) | (16'(pat) << 7) | (16'(st) << 6);
  endfunction

  task automatic wait_done(output int dcyc);
    dcyc = -1;
    for (int i = 0; i < 3 * FRAME; i++) begin
      @(negedge clk); #3;
      if (done) begin dcyc = cyc; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0, dc, w0;
    repeat (3) @(negedge clk);
    check(cr_rdata == 0 && !up_busy && !done && !cm_we, "R1", cr_rdata, 0);
    rst_n = 1;
    @(negedge clk); #3;
    check(cr_rdata == 0 && !up_busy && !cm_we, "R1", {up_busy, cm_we}, 0);

    // R6: start edge without arm
    cr_write(crv(0, 3'd5, 1));
    w0 = writes;
    repeat (2 * FRAME) @(negedge clk);
    #3;
    check(!up_busy, "R6", up_busy, 0);
    check(writes == w0, "R6", writes, w0);
    check(cr_rdata == crv(0, 3'd5, 1), "R6", cr_rdata, crv(0, 3'd5, 1));

    // R9: start already 1, now armed: no edge
    cr_write(crv(1, 3'd5, 1));
    repeat (2 * FRAME) @(negedge clk);
    #3;
    check(!up_busy && writes == w0, "R9", writes, w0);

    // full sweep with pattern 5, held CPU write and blocked CR write during it
    cr_write(crv(1, 3'd5, 0));
    cpu_write(8'd17, 16'h1234);
    @(negedge clk); cr_we = 1; cr_wdata = crv(1, 3'd5, 1);
    t0 = cyc + 1;
    @(negedge clk); cr_we = 0; #3;
    check(up_busy, "R3", up_busy, 1);
    cr_write(16'h0000);
    #3;
    check(cr_rdata == crv(1, 3'd5, 1), "R8", cr_rdata, crv(1, 3'd5, 1));
    fork
      cpu_write(8'd40, 16'hBEEF);
      wait_done(dc);
    join
    check(dc > 0 && (dc - t0) <= 2 * FRAME, "R10", dc - t0, 2 * FRAME);
    check(!cr_rdata[6], "R5", cr_rdata[6], 0);
    begin
      int bad = 0;
      for (int a = 0; a < N; a++)
        if (a != 40 && mem[a] != 16'hA000) bad++;
      check(bad == 0, "R4", bad, 0);
    end
    check(mem[40] == 16'hBEEF, "R7", mem[40], 16'hBEEF);

    // second sweep with pattern 2 overwrites earlier CPU data
    cr_write(crv(1, 3'd2, 1));
    wait_done(dc);
    check(dc > 0, "R5", dc, 1);
    check(mem[40] == 16'h4000 && mem[0] == 16'h4000 && mem[N-1] == 16'h4000, "R4", mem[40], 16'h4000);
    cpu_write(8'd3, 16'h00FF);
    repeat (2) @(negedge clk);
    check(mem[3] == 16'h00FF, "R7", mem[3], 16'h00FF);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule